// File: doc/BRIEF.md
# Oversampled Serial Receiver with Error Flags

This block receives asynchronous serial characters on a single line, using a clock enable that pulses sixteen times per bit period. It waits in a hunt state for a falling edge, confirms the start bit at mid-bit, then shifts in eight data bits least significant bit first. An optional ninth bit carries parity, and a stop bit ends the frame. Each bit is decided by a majority vote of three samples taken around the middle of the bit.

The finished character and its status are read over a small read-only register bus. Five flags describe the receiver: data full, overrun, framing error, parity error and line activity. The three error flags and the data-full flag clear together, and only through a fixed pair of reads: the status register first, then the data register. A framing error stops the receiver from accepting any new character until software has cleared it. The activity flag rises on the first low sample seen while hunting and falls only once a whole character time of idle line has gone by.

Top module: `uart_rx_status`

## Requirements
- R1: A frame is one low start bit, eight data bits least significant bit first, a parity bit when `par_en` is 1, and a high stop bit. When the stop bit has been decided, `rx_full` rises and the character can be read at address 2.
- R2: Each bit value is the majority of the synchronised line samples in oversample slots 8, 9 and 10 of that bit, so a single deviating sample has no effect. If the start bit votes high, the receiver goes back to hunting and no character is produced.
- R3: `par_err` is set only when `par_en` is 1 and the received parity bit does not match the data. With `par_odd` at 0 the eight data bits plus the parity bit must hold an even number of ones; with `par_odd` at 1 they must hold an odd number.
- R4: A stop bit that votes low sets `frame_err` in the same cycle as `rx_full`. While `frame_err` is 1, no start bit is accepted, so further characters are lost and cannot cause an overrun.
- R5: A character that completes while `rx_full` is 1 sets `overrun`, leaves the stored data unchanged, and sets neither `frame_err` nor `par_err`.
- R6: `rx_full`, `overrun`, `frame_err` and `par_err` clear only when a read of address 0, made while one of them is set, is followed directly by a read of address 2. Any other read in between cancels the pending clear, and a data read alone clears nothing. Reset clears all flags.
- R7: `rx_active` rises in the first oversample slot in which the receiver, while hunting, sees a low synchronised line. The line passes through a two-flop synchroniser first.
- R8: `rx_active` falls once the synchronised line has been high for 160 consecutive oversample slots, or 176 when `par_en` is 1, and it does not fall before that.
- R9: Address 0 reads {rx_full, 0, 0, 0, overrun, 0, frame_err, par_err}, with rx_full in bit 7. Address 1 reads rx_active in bit 0 and zero in bits 7 to 1. Address 3 reads zero. Reads of addresses 1 and 3 change no flags.
- R10: Receiver state advances only in cycles where `tick16` is 1, so characters are received correctly at any spacing of the enable pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Oversample enable, sixteen pulses per bit |
| rxd | input | 1 | Serial line, idle high |
| par_en | input | 1 | 1 adds a parity bit to the frame and checks it |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| rd_stb | input | 1 | Read strobe, one cycle per access |
| rd_addr | input | 2 | Register address of the read |
| rd_data | output | 8 | Read data for `rd_addr`, combinational |
| rx_full | output | 1 | Unread character held |
| overrun | output | 1 | A character arrived while the previous one was unread |
| frame_err | output | 1 | Stop bit of the held character was low |
| par_err | output | 1 | Parity of the held character was wrong |
| rx_active | output | 1 | Reception in progress since the last idle character |

## Verification
The hardest situation to reach is a framing error that is still set while a second, valid character arrives. Normally a flag set leads straight to a clear. The stimulus sends a frame with a low stop bit and then a full good frame without touching the bus. It then shows that the second frame was discarded: the status register shows no overrun, and the read that follows returns the first character. Interrupted clear sequences are reached the same way, by placing address 1 or address 3 reads, or a bare data read, between the status read and the data read while a parity error is held.

// File: rtl/uart_rx_status.sv
module uart_rx_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rxd,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       rd_stb,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       rx_full,
  output logic       overrun,
  output logic       frame_err,
  output logic       par_err,
  output logic       rx_active
);

  localparam logic [1:0] ADR_STAT  = 2'd0;
  localparam logic [1:0] ADR_STAT2 = 2'd1;
  localparam logic [1:0] ADR_DATA  = 2'd2;
  localparam logic [7:0] IDLE_NOPAR = 8'd160;
  localparam logic [7:0] IDLE_PAR   = 8'd176;

  typedef enum logic [2:0] {S_HUNT, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t        st;
  logic [1:0] sync;
  logic [3:0] rt;
  logic [2:0] bcnt;
  logic       s8, s9, pbit, arm;
  logic [7:0] sh, data_q, idle_cnt;

  wire       rxs       = sync[1];
  wire [3:0] slot      = rt + 4'd1;
  wire       vote      = (s8 & s9) | (rxs & (s8 | s9));
  wire       busy_tick = tick16 && (st != S_HUNT);
  wire       start_det = tick16 && (st == S_HUNT) && !rxs && !frame_err;
  wire       done      = busy_tick && (st == S_STOP) && (slot == 4'd10);
  wire       new_ok    = done && !rx_full;
  wire       new_ovr   = done && rx_full;
  wire       pe_calc   = par_en && ((^sh ^ pbit) != par_odd);
  wire       clr       = rd_stb && (rd_addr == ADR_DATA) && arm;
  wire [7:0] idle_lim  = par_en ? IDLE_PAR : IDLE_NOPAR;
  wire       idle_st   = (st == S_HUNT);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_HUNT;
      rt   <= 4'd0;
      bcnt <= 3'd0;
      s8   <= 1'b1;
      s9   <= 1'b1;
      pbit <= 1'b0;
      sh   <= 8'd0;
    end else if (start_det) begin
      st <= S_START;
      rt <= 4'd1;
    end else if (busy_tick) begin
      rt <= slot;
      if (slot == 4'd8) s8 <= rxs;
      if (slot == 4'd9) s9 <= rxs;
      if (slot == 4'd10) begin
        case (st)
          S_START: if (vote) st <= S_HUNT;
          S_DATA:  sh <= {vote, sh[7:1]};
          S_PAR:   pbit <= vote;
          S_STOP:  st <= S_HUNT;
          default: ;
        endcase
      end
      if (slot == 4'd0) begin
        case (st)
          S_START: begin st <= S_DATA; bcnt <= 3'd0; end
          S_DATA:
            if (bcnt == 3'd7) st <= par_en ? S_PAR : S_STOP;
            else              bcnt <= bcnt + 3'd1;
          S_PAR:   st <= S_STOP;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_full   <= 1'b0;
      overrun   <= 1'b0;
      frame_err <= 1'b0;
      par_err   <= 1'b0;
      data_q    <= 8'd0;
      arm       <= 1'b0;
    end else begin
      if (rd_stb)
        arm <= (rd_addr == ADR_STAT) && (rx_full | overrun | frame_err | par_err);
      if (new_ok)       rx_full <= 1'b1;
      else if (clr)     rx_full <= 1'b0;
      if (new_ovr)      overrun <= 1'b1;
      else if (clr)     overrun <= 1'b0;
      if (new_ok && !vote)  frame_err <= 1'b1;
      else if (clr)         frame_err <= 1'b0;
      if (new_ok && pe_calc) par_err <= 1'b1;
      else if (clr)          par_err <= 1'b0;
      if (new_ok) data_q <= sh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt  <= 8'd0;
      rx_active <= 1'b0;
    end else if (tick16) begin
      if (!rxs)                  idle_cnt <= 8'd0;
      else if (idle_cnt < idle_lim) idle_cnt <= idle_cnt + 8'd1;
      if (start_det)
        rx_active <= 1'b1;
      else if (rxs && (idle_cnt == idle_lim - 8'd1))
        rx_active <= 1'b0;
    end
  end

  always_comb begin
    case (rd_addr)
      ADR_STAT:  rd_data = {rx_full, 3'b000, overrun, 1'b0, frame_err, par_err};
      ADR_STAT2: rd_data = {7'd0, rx_active};
      ADR_DATA:  rd_data = data_q;
      default:   rd_data = 8'd0;
    endcase
  end

endmodule

// File: rtl/uart_rx_status_chk.sv
module uart_rx_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       par_en,
  input logic       rd_stb,
  input logic [1:0] rd_addr,
  input logic [7:0] rd_data,
  input logic       rx_full,
  input logic       overrun,
  input logic       frame_err,
  input logic       par_err,
  input logic       rx_active,
  input logic       hunting,
  input logic [7:0] data_q
);

  a_r4_fe_with_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_err) |-> $rose(rx_full));

  a_r4_fe_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> hunting);

  a_r5_ovr_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> ($stable(data_q) && !$rose(frame_err) && !$rose(par_err)));

  a_r3_pe_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(par_err) |-> par_en);

  a_r6_fe_clear_by_data: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_err) |-> $past(rd_stb && rd_addr == 2'd2));

  a_r6_pe_clear_by_data: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(par_err) |-> $past(rd_stb && rd_addr == 2'd2));

  a_r6_ovr_clear_by_data: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(overrun) |-> $past(rd_stb && rd_addr == 2'd2));

  a_r7_active_at_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> rx_active);

  a_r9_stat2_layout: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 2'd1) |-> (rd_data == {7'd0, rx_active}));

endmodule

bind uart_rx_status uart_rx_status_chk chk (
  .clk(clk), .rst_n(rst_n), .par_en(par_en), .rd_stb(rd_stb), .rd_addr(rd_addr),
  .rd_data(rd_data), .rx_full(rx_full), .overrun(overrun), .frame_err(frame_err),
  .par_err(par_err), .rx_active(rx_active), .hunting(idle_st), .data_q(data_q)
);

// File: tb/tb_uart_rx_status.sv
module tb_uart_rx_status;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, tick16 = 0, rxd = 1, par_en = 0, par_odd = 0, rd_stb = 0;
  logic [1:0] rd_addr = 0;
  logic [7:0] rd_data;
  logic rx_full, overrun, frame_err, par_err, rx_active;
  int n_chk = 0, n_bad = 0, div = 1, dcnt = 0;
  bit fin = 0;

  uart_rx_status dut (.clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .par_en(par_en), .par_odd(par_odd), .rd_stb(rd_stb), .rd_addr(rd_addr),
    .rd_data(rd_data), .rx_full(rx_full), .overrun(overrun), .frame_err(frame_err),
    .par_err(par_err), .rx_active(rx_active));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (dcnt >= div - 1) begin dcnt = 0; tick16 = 1; end
    else begin dcnt = dcnt + 1; tick16 = 0; end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] stat(input bit f, input bit o, input bit fe, input bit pe);
    return {f, 3'b000, o, 1'b0, fe, pe};
  endfunction

  task automatic wait_ticks(input int n);
    int k = 0;
    while (k < n) begin
      @(posedge clk);
      if (tick16) k++;
    end
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    rd_stb = 1; rd_addr = a;
    #1 v = rd_data;
    @(posedge clk); @(negedge clk);
    rd_stb = 0; rd_addr = 0;
  endtask

  task automatic send_bit(input bit b, input bit glitch);
    for (int k = 0; k < 16; k++) begin
      rxd = (glitch && k == 7) ? ~b : b;
      wait_ticks(1);
    end
    rxd = 1;
  endtask

  task automatic send_frame(input logic [7:0] d, input bit pen, input bit pb,
                            input bit stopb, input bit glitch);
    send_bit(0, glitch);
    for (int i = 0; i < 8; i++) send_bit(d[i], glitch);
    if (pen) send_bit(pb, glitch);
    send_bit(stopb, glitch);
  endtask

  function automatic bit pbit_of(input logic [7:0] d, input bit odd);
    return odd ? ~(^d) : (^d);
  endfunction

  task automatic rx_check(input logic [7:0] d, input bit pen, input bit odd,
                          input bit bad, input bit glitch, input string req);
    logic [7:0] v;
    par_en = pen; par_odd = odd;
    send_frame(d, pen, pbit_of(d, odd) ^ bad, 1'b1, glitch);
    rd(2'd0, v); check(req, v, stat(1, 0, 0, pen & bad));
    rd(2'd2, v); check(req, v, d);
    rd(2'd0, v); check("R6 cleared after sequence", v, 8'h00);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R6 reset state, R9 map
    check("R6 reset flags", {3'b0, rx_full, overrun, frame_err, par_err, rx_active}, 8'h00);
    rd(2'd0, v); check("R9 status at reset", v, 8'h00);
    rd(2'd1, v); check("R9 status2 at reset", v, 8'h00);
    rd(2'd2, v); check("R9 data at reset", v, 8'h00);
    rd(2'd3, v); check("R9 addr3 zero", v, 8'h00);

    // R1 all data values, no parity
    for (int d = 0; d < 256; d++) rx_check(d[7:0], 0, 0, 0, 0, "R1 data sweep");

    // R3 parity sweep, both senses, good and bad parity
    for (int o = 0; o < 2; o++)
      for (int i = 0; i < 64; i++)
        rx_check(8'((i * 53 + 7) & 255), 1, o[0], i[0], 0, "R3 parity sweep");

    // R2 single-sample glitch inside every bit
    for (int i = 0; i < 8; i++) rx_check(8'(i * 37 + 5), i[1], i[2], 0, 1, "R2 glitch vote");

    // R2 noise start, R7 active rises anyway
    par_en = 0;
    wait_ticks(200);
    rxd = 0; wait_ticks(3); rxd = 1; wait_ticks(40);
    check("R2 noise start no char", {7'd0, rx_full}, 8'h00);
    check("R7 active after noise", {7'd0, rx_active}, 8'h01);
    wait_ticks(200);
    check("R8 active idle", {7'd0, rx_active}, 8'h00);

    // R7 exact rise slot, R8 idle clear timing
    rxd = 0; wait_ticks(1);
    check("R7 not yet active", {7'd0, rx_active}, 8'h00);
    wait_ticks(2);
    rd(2'd1, v); check("R7 active in status2", v, 8'h01);
    wait_ticks(12);
    for (int i = 0; i < 8; i++) send_bit(1'b0, 0);
    send_bit(1'b1, 0);
    wait_ticks(100);
    check("R8 still active before idle char", {7'd0, rx_active}, 8'h01);
    wait_ticks(60);
    check("R8 cleared after idle char", {7'd0, rx_active}, 8'h00);
    rd(2'd0, v); rd(2'd2, v); check("R1 zero char", v, 8'h00);

    // R5 overrun with bad-stop second char
    send_frame(8'h3C, 0, 0, 1, 0);
    send_frame(8'hA5, 0, 0, 0, 0);
    wait_ticks(20);
    rd(2'd0, v); check("R5 overrun no fe", v, stat(1, 1, 0, 0));
    rd(2'd2, v); check("R5 old data kept", v, 8'h3C);
    rd(2'd0, v); check("R5 overrun cleared", v, 8'h00);

    // R4 framing error blocks reception
    send_frame(8'h5A, 0, 0, 0, 0);
    wait_ticks(20);
    check("R4 fe port", {6'd0, rx_full, frame_err}, 8'h03);
    send_frame(8'h11, 0, 0, 1, 0);
    wait_ticks(20);
    rd(2'd0, v); check("R4 blocked no overrun", v, stat(1, 0, 1, 0));
    rd(2'd2, v); check("R4 first char kept", v, 8'h5A);
    rd(2'd0, v); check("R4 fe cleared", v, 8'h00);
    rx_check(8'h77, 0, 0, 0, 0, "R4 reception resumes");

    // R6 interrupted clear sequences
    par_en = 1; par_odd = 0;
    send_frame(8'h0F, 1, 1, 1, 0);
    rd(2'd2, v); check("R6 bare data read", v, 8'h0F);
    rd(2'd0, v); check("R6 no clear without arm", v, stat(1, 0, 0, 1));
    rd(2'd1, v);
    rd(2'd2, v);
    rd(2'd0, v); check("R6 addr1 cancels arm", v, stat(1, 0, 0, 1));
    rd(2'd3, v); check("R9 addr3 reads zero", v, 8'h00);
    rd(2'd2, v);
    rd(2'd0, v); check("R6 addr3 cancels arm", v, stat(1, 0, 0, 1));
    rd(2'd2, v);
    rd(2'd0, v); check("R6 sequence clears pe", v, 8'h00);

    // R6 reset clears held errors
    send_frame(8'h42, 1, 0, 0, 0);
    wait_ticks(20);
    rst_n = 0; @(negedge clk); @(negedge clk); rst_n = 1; @(negedge clk);
    check("R6 reset clears flags", {4'd0, rx_full, overrun, frame_err, par_err}, 8'h00);

    // R10 sparse enable pulses
    div = 3;
    wait_ticks(4);
    rx_check(8'hC3, 1, 1, 0, 0, "R10 div3 a");
    rx_check(8'h96, 1, 0, 1, 0, "R10 div3 b");
    rx_check(8'h01, 0, 0, 0, 0, "R10 div3 c");
    div = 1;

    fin = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule